// File: doc/BRIEF.md
# Quad-Phase Hit Time and Width Recorder

This block timestamps pulses on a bank of digitised photodetector lines. Each line is sampled four times per 4 ns system clock, on both edges of a 0° clock and a 90° clock, so each sample covers 1 ns. Those four samples reach the block as one 4-bit vector per line per cycle, already aligned to the system clock. For every pulse the block finds where the line goes high and where it goes low again. It then forms a record holding the line number, the start time and the pulse width in nanoseconds, the time over threshold.

Each line has its own edge finder, which writes into a short private queue. A round-robin arbiter merges all the queues into a single record stream with valid/ready flow control. The consumer may hold ready low for as long as it likes. While it does, the offered record does not change and the queues absorb new hits. A hit that finds its queue full is discarded, and a sticky per-line flag records the loss.

Top module: `tdc_tot_top`

## Requirements
- R1: After reset, rec_valid is low and ovf_flags is all zero. The coarse time counter reads 0 in the first clock cycle after reset is released and then advances by one each cycle.
- R2: Line c uses bits [4c+3:4c] of smp_bus. Within that field, bit k holds sample k, each sample covering 1 ns. The samples run oldest first: bit 0 is the 0° rising edge, bit 1 the 90° rising edge, bit 2 the 0° falling edge and bit 3 the 90° falling edge.
- R3: A pulse starts at the first low-to-high step in the 5-bit sequence formed by the last sample of the previous cycle (taken as 0 after reset) followed by the four current samples. The record's fine time (0 to 3) is the index of the first high sample, and its coarse time is the counter value of that cycle.
- R4: The width is the number of high samples from the first high sample up to the first low sample, counted across as many cycles as the pulse lasts. The record is issued after the cycle that contains the first low sample.
- R5: A pulse that both starts and ends inside one vector is reported from that vector, with width equal to its count of high samples. After a pulse has closed, any further pulse that starts later in the same vector is not reported.
- R6: The width saturates at 255: a pulse with 255 or more high samples is reported as 255, and one with 254 high samples is reported as 254.
- R7: A record moves to the consumer on every cycle in which rec_valid and rec_ready are both high. While rec_valid is high and rec_ready is low, rec_valid stays high and rec_chan, rec_coarse, rec_fine and rec_tot stay unchanged.
- R8: Records from one line leave in the order their pulses started. After a transfer from line c, the next record comes from the first non-empty line after c in increasing order, wrapping from the top line back to line 0. After reset the search starts at line 0.
- R9: Each line queues up to 4 records. A hit that arrives at a full queue is discarded and the line's ovf_flags bit goes high. The bit stays high until reset, and the flags of other lines do not change.
- R10: A hit that arrives at a full queue in the same cycle that queue hands a record to the consumer is stored, and no overflow is flagged.
- R11: rec_chan never names a line outside 0 to N_CH-1, and no record reports a width of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 250 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_bus | input | 124 | Four samples per line, 31 lines |
| rec_valid | output | 1 | A record is offered |
| rec_ready | input | 1 | The consumer accepts the offered record |
| rec_chan | output | 5 | Line number of the record |
| rec_coarse | output | 28 | Cycle count at the pulse start |
| rec_fine | output | 2 | Index of the first high sample |
| rec_tot | output | 8 | Pulse width in 1 ns units |
| ovf_flags | output | 31 | Sticky per-line record-loss flags |

## Verification
Two functions can meet in the same clock edge. A new hit can be written into a line's full queue just as the arbiter drains that same queue, and a new line can become non-empty while the output is stalled on another line. For the first case, the bench fills one queue with rec_ready low. It then applies a fifth pulse and raises rec_ready for exactly the one cycle in which that hit is written. It judges the result by a clear overflow flag and the arrival of all five records. For the second case, the bench injects a hit on a line that the search would reach first, while the consumer is stalled. It expects the stalled record to stay in place and the new line to take its round-robin turn afterwards.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  // Four samples per system clock: both edges of a 0 deg and a 90 deg clock.
  localparam int unsigned SLOTS  = 4;
  localparam int unsigned FINE_W = 2;

  typedef enum logic {
    PL_IDLE = 1'b0,
    PL_HIGH = 1'b1
  } pulse_st_e;
endpackage

// File: rtl/tdc_edge_chan.sv
module tdc_edge_chan
  import tdc_pkg::*;
#(
  parameter int unsigned CNT_W = 28,
  parameter int unsigned TOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOTS-1:0]  smp,
  input  logic [CNT_W-1:0]  now,
  output logic              hit_v,
  output logic [CNT_W-1:0]  hit_coarse,
  output logic [FINE_W-1:0] hit_fine,
  output logic [TOT_W-1:0]  hit_tot
);
  localparam logic [TOT_W:0] TOT_MAX = {1'b0, {TOT_W{1'b1}}};

  pulse_st_e         st_q;
  logic              last_q;
  logic [TOT_W-1:0]  run_q;
  logic [CNT_W-1:0]  lead_c_q;
  logic [FINE_W-1:0] lead_f_q;

  logic [SLOTS:0]    ext;
  logic              rise_ok, fall_ok;
  logic [FINE_W-1:0] rise_at, fall_at;
  logic [TOT_W:0]    close_sum, grow_sum;
  logic [TOT_W-1:0]  close_tot, grow_tot, span;

  // ext[0] is the final sample of the previous cycle, ext[k+1] is sample k now.
  assign ext = {smp, last_q};

  always_comb begin
    rise_ok = 1'b0;
    rise_at = '0;
    fall_ok = 1'b0;
    fall_at = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (!rise_ok && !ext[k] && ext[k+1]) begin
        rise_ok = 1'b1;
        rise_at = FINE_W'(k);
      end
    end
    // A close counts for an open pulse, or after a start found in this vector.
    for (int k = 0; k < SLOTS; k++) begin
      if (!fall_ok && ext[k] && !ext[k+1] &&
          (st_q == PL_HIGH || (rise_ok && k > int'(rise_at)))) begin
        fall_ok = 1'b1;
        fall_at = FINE_W'(k);
      end
    end
  end

  assign close_sum = {1'b0, run_q} + (TOT_W+1)'(fall_at);
  assign grow_sum  = {1'b0, run_q} + (TOT_W+1)'(SLOTS);
  assign close_tot = (close_sum > TOT_MAX) ? {TOT_W{1'b1}} : close_sum[TOT_W-1:0];
  assign grow_tot  = (grow_sum > TOT_MAX) ? {TOT_W{1'b1}} : grow_sum[TOT_W-1:0];
  assign span      = TOT_W'(SLOTS) - TOT_W'(rise_at);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= PL_IDLE;
      last_q     <= 1'b0;
      run_q      <= '0;
      lead_c_q   <= '0;
      lead_f_q   <= '0;
      hit_v      <= 1'b0;
      hit_coarse <= '0;
      hit_fine   <= '0;
      hit_tot    <= '0;
    end else begin
      last_q <= smp[SLOTS-1];
      hit_v  <= 1'b0;
      if (st_q == PL_HIGH) begin
        if (fall_ok) begin
          hit_v      <= 1'b1;
          hit_coarse <= lead_c_q;
          hit_fine   <= lead_f_q;
          hit_tot    <= close_tot;
          st_q       <= PL_IDLE;
        end else begin
          run_q <= grow_tot;
        end
      end else if (rise_ok) begin
        if (fall_ok) begin
          hit_v      <= 1'b1;
          hit_coarse <= now;
          hit_fine   <= rise_at;
          hit_tot    <= TOT_W'(fall_at) - TOT_W'(rise_at);
        end else begin
          st_q     <= PL_HIGH;
          lead_c_q <= now;
          lead_f_q <= rise_at;
          run_q    <= span;
        end
      end
    end
  end
endmodule

// File: rtl/tdc_rec_fifo.sv
module tdc_rec_fifo #(
  parameter int unsigned W     = 38,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         nempty,
  output logic         drop
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          full, take, put;

  assign full   = (cnt_q == CW'(DEPTH));
  assign nempty = (cnt_q != '0);
  assign take   = pop && nempty;
  // A slot freed by a read in this cycle is available to a write in this cycle.
  assign put    = push && (!full || take);
  assign drop   = push && full && !take;
  assign dout   = mem[rp_q];

  always_ff @(posedge clk) begin
    if (put) mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (put)  wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (take) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      if (put && !take)      cnt_q <= cnt_q + 1'b1;
      else if (take && !put) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/tdc_rr_arb.sv
module tdc_rr_arb #(
  parameter int unsigned N = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic                 ready,
  output logic                 valid,
  output logic [$clog2(N)-1:0] grant,
  output logic [N-1:0]         pop
);
  localparam int unsigned IW = $clog2(N);

  logic [IW-1:0] last_q, lock_idx_q, pick;
  logic          lock_q, found;

  always_comb begin : p_pick
    int unsigned idx;
    idx   = 0;
    found = 1'b0;
    pick  = last_q;
    for (int i = 1; i <= N; i++) begin
      idx = int'(last_q) + i;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        found = 1'b1;
        pick  = IW'(idx);
      end
    end
  end

  // A stalled offer keeps its line even if an earlier line fills meanwhile.
  assign grant = lock_q ? lock_idx_q : pick;
  assign valid = lock_q || found;

  always_comb begin
    for (int i = 0; i < N; i++) pop[i] = valid && ready && (grant == IW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q     <= IW'(N - 1);
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else if (valid && ready) begin
      last_q <= grant;
      lock_q <= 1'b0;
    end else if (valid) begin
      lock_q     <= 1'b1;
      lock_idx_q <= grant;
    end else begin
      lock_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tdc_tot_top.sv
module tdc_tot_top
  import tdc_pkg::*;
#(
  parameter int unsigned N_CH       = 31,
  parameter int unsigned CNT_W      = 28,
  parameter int unsigned TOT_W      = 8,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_CH*SLOTS-1:0]   smp_bus,
  output logic                    rec_valid,
  input  logic                    rec_ready,
  output logic [$clog2(N_CH)-1:0] rec_chan,
  output logic [CNT_W-1:0]        rec_coarse,
  output logic [FINE_W-1:0]       rec_fine,
  output logic [TOT_W-1:0]        rec_tot,
  output logic [N_CH-1:0]         ovf_flags
);
  localparam int unsigned CH_W = $clog2(N_CH);
  localparam int unsigned RW   = CNT_W + FINE_W + TOT_W;

  logic [CNT_W-1:0] now_q;
  logic [RW-1:0]    head [N_CH];
  logic [N_CH-1:0]  nempty, pop, drop;
  logic [N_CH-1:0]  ovf_q;
  logic [CH_W-1:0]  grant;

  always_ff @(posedge clk) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_q + 1'b1;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic              hv;
    logic [CNT_W-1:0]  hc;
    logic [FINE_W-1:0] hf;
    logic [TOT_W-1:0]  ht;

    tdc_edge_chan #(.CNT_W(CNT_W), .TOT_W(TOT_W)) i_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .smp        (smp_bus[c*SLOTS +: SLOTS]),
      .now        (now_q),
      .hit_v      (hv),
      .hit_coarse (hc),
      .hit_fine   (hf),
      .hit_tot    (ht)
    );

    tdc_rec_fifo #(.W(RW), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (hv),
      .din    ({hc, hf, ht}),
      .pop    (pop[c]),
      .dout   (head[c]),
      .nempty (nempty[c]),
      .drop   (drop[c])
    );
  end

  tdc_rr_arb #(.N(N_CH)) i_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (nempty),
    .ready (rec_ready),
    .valid (rec_valid),
    .grant (grant),
    .pop   (pop)
  );

  assign rec_chan = grant;
  assign {rec_coarse, rec_fine, rec_tot} = head[grant];

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_q <= '0;
    else        ovf_q <= ovf_q | drop;
  end
  assign ovf_flags = ovf_q;
endmodule

// File: rtl/tdc_tot_chk.sv
module tdc_tot_chk #(
  parameter int unsigned N_CH  = 31,
  parameter int unsigned CNT_W = 28,
  parameter int unsigned TOT_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rec_valid,
  input logic                    rec_ready,
  input logic [$clog2(N_CH)-1:0] rec_chan,
  input logic [CNT_W-1:0]        rec_coarse,
  input logic [1:0]              rec_fine,
  input logic [TOT_W-1:0]        rec_tot,
  input logic [N_CH-1:0]         ovf_flags
);
  // R7: a stalled offer is held unchanged
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_chan) &&
      $stable(rec_coarse) && $stable(rec_fine) && $stable(rec_tot)));

  // R9: loss flags never clear outside reset
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags)));

  // R11: only existing lines are named
  a_r11_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (int'(rec_chan) < N_CH));

  // R11: a reported pulse has at least one high sample
  a_r11_tot_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_tot != '0));
endmodule

bind tdc_tot_top tdc_tot_chk #(.N_CH(N_CH), .CNT_W(CNT_W), .TOT_W(TOT_W)) i_tdc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rec_valid  (rec_valid),
  .rec_ready  (rec_ready),
  .rec_chan   (rec_chan),
  .rec_coarse (rec_coarse),
  .rec_fine   (rec_fine),
  .rec_tot    (rec_tot),
  .ovf_flags  (ovf_flags)
);

// File: tb/test_tdc_tot_top.sv
`timescale 1ns/1ps
module test_tdc_tot_top;
  localparam int CLK_P = 4;
  localparam int NCH   = 31;

  typedef struct packed {int ch; int coarse; int fine; int tot;} rec_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH*4-1:0] smp_bus = '0;
  logic           rec_ready = 1'b0;
  logic           rec_valid;
  logic [4:0]     rec_chan;
  logic [27:0]    rec_coarse;
  logic [1:0]     rec_fine;
  logic [7:0]     rec_tot;
  logic [NCH-1:0] ovf_flags;

  int   n_chk = 0, n_fail = 0, cyc = 0;
  rec_t got_q[$];
  rec_t exp_q[$];

  tdc_tot_top i_tdc_tot_top (
    .clk(clk), .rst_n(rst_n), .smp_bus(smp_bus), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_chan(rec_chan), .rec_coarse(rec_coarse),
    .rec_fine(rec_fine), .rec_tot(rec_tot), .ovf_flags(ovf_flags)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // Transfers are logged a quarter period after the falling edge.
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (rst_n && rec_valid && rec_ready)
      got_q.push_back('{int'(rec_chan), int'(rec_coarse), int'(rec_fine), int'(rec_tot)});
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, longint act, longint expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic expect_rec(int ch, int c, int f, int t);
    exp_q.push_back('{ch, c, f, t});
  endtask

  task automatic check_recs(string tag, bit exact);
    chk({tag, " record count"}, got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size()) begin
      for (int i = 0; i < exp_q.size(); i++) begin
        rec_t g;
        if (exact) g = got_q[i];
        else begin
          int want = 0, seen = 0;
          g = '{-1, -1, -1, -1};
          for (int j = 0; j < i; j++) if (exp_q[j].ch == exp_q[i].ch) want++;
          for (int j = 0; j < got_q.size(); j++)
            if (got_q[j].ch == exp_q[i].ch) begin
              if (seen == want) g = got_q[j];
              seen++;
            end
        end
        n_chk++;
        if (g != exp_q[i]) begin
          n_fail++;
          $display("FAIL %s rec %0d: actual ch=%0d c=%0d f=%0d t=%0d expected ch=%0d c=%0d f=%0d t=%0d",
                   tag, i, g.ch, g.coarse, g.fine, g.tot,
                   exp_q[i].ch, exp_q[i].coarse, exp_q[i].fine, exp_q[i].tot);
        end
      end
    end
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_bus = '0; rec_ready = 1'b0;
    tick(3);
    rst_n = 1'b1;
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic set_ch(int ch, logic [3:0] v);
    smp_bus[ch*4 +: 4] = v;
  endtask

  // R1: idle state after reset
  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 rec_valid after reset", rec_valid, 0);
    chk("R1 ovf_flags after reset", ovf_flags, 0);
  endtask

  // R1 R2 R3 R5: single-vector pulses, every fine position, counter start
  task automatic t_short();
    do_reset();
    rec_ready = 1'b1;
    set_ch(0, 4'b0110); set_ch(30, 4'b0001);
    expect_rec(0, cyc, 1, 2); expect_rec(30, cyc, 0, 1);
    chk("R1 first coarse", cyc, 0);
    tick();
    set_ch(0, 4'b0000); set_ch(30, 4'b0010); set_ch(7, 4'b1000); set_ch(3, 4'b0101);
    expect_rec(30, cyc, 1, 1); expect_rec(3, cyc, 0, 1);
    expect_rec(7, cyc, 3, 1);
    tick();
    set_ch(30, 4'b0100); set_ch(7, 4'b0000); set_ch(3, 4'b0000);
    expect_rec(30, cyc, 2, 1);
    tick();
    set_ch(30, 4'b1000);
    expect_rec(30, cyc, 3, 1);
    tick();
    set_ch(30, 4'b0000);
    tick(20);
    check_recs("R2 R3 R5 short pulses", 1'b0);
  endtask

  // R4: width over several cycles
  task automatic t_span();
    int a;
    rec_ready = 1'b1;
    a = cyc;
    set_ch(12, 4'b1100); tick();
    set_ch(12, 4'b1111); tick(3);
    set_ch(12, 4'b0011); tick();
    set_ch(12, 4'b0000); tick(10);
    expect_rec(12, a, 2, 16);
    check_recs("R4 multi-cycle width", 1'b0);
  endtask

  // R6: saturation and the value just below it
  task automatic t_sat();
    int a;
    rec_ready = 1'b1;
    a = cyc;
    set_ch(20, 4'b1111); set_ch(21, 4'b1100); tick();
    set_ch(21, 4'b1111); tick(63);
    set_ch(21, 4'b0000); tick(7);
    set_ch(20, 4'b0000); tick(10);
    expect_rec(21, a, 2, 254); expect_rec(20, a, 0, 255);
    check_recs("R6 saturation", 1'b0);
  endtask

  // R7 R8: stall hold and round-robin order
  task automatic t_rr();
    int a;
    logic [4:0] c0;
    logic [27:0] k0;
    do_reset();
    a = cyc;
    set_ch(2, 4'b0001); set_ch(5, 4'b0001); set_ch(9, 4'b0001); tick(2);
    set_ch(2, 4'b0000); set_ch(5, 4'b0000); set_ch(9, 4'b0000); tick();
    set_ch(0, 4'b0001); tick();
    set_ch(0, 4'b0000); tick(3);
    #1;
    c0 = rec_chan; k0 = rec_coarse;
    chk("R7 valid while stalled", rec_valid, 1);
    chk("R7 stalled line", c0, 2);
    tick(2);
    #1;
    chk("R7 valid still held", rec_valid, 1);
    chk("R7 line held", rec_chan, c0);
    chk("R7 coarse held", rec_coarse, k0);
    tick();
    rec_ready = 1'b1;
    tick(15);
    expect_rec(2, a, 0, 1); expect_rec(5, a, 0, 1); expect_rec(9, a, 0, 1);
    expect_rec(0, a + 3, 0, 1);
    expect_rec(2, a + 1, 0, 1); expect_rec(5, a + 1, 0, 1); expect_rec(9, a + 1, 0, 1);
    check_recs("R8 round-robin order", 1'b1);
  endtask

  // R9: overflow drop and sticky flag
  task automatic t_ovf();
    int a, b;
    do_reset();
    a = cyc;
    set_ch(4, 4'b0001); tick(5);
    set_ch(4, 4'b0000); tick(3);
    chk("R9 flag on full line only", ovf_flags, 32'h10);
    rec_ready = 1'b1;
    tick(10);
    for (int i = 0; i < 4; i++) expect_rec(4, a + i, 0, 1);
    check_recs("R9 fifth hit dropped", 1'b1);
    chk("R9 flag sticky", ovf_flags, 32'h10);
    b = cyc;
    set_ch(4, 4'b0001); tick();
    set_ch(4, 4'b0000); tick(6);
    expect_rec(4, b, 0, 1);
    check_recs("R9 line usable after loss", 1'b1);
  endtask

  // R10: write into full queue while it drains
  task automatic t_same();
    int a;
    do_reset();
    a = cyc;
    set_ch(6, 4'b0001); tick(5);
    set_ch(6, 4'b0000); rec_ready = 1'b1; tick();
    rec_ready = 1'b0; tick(3);
    chk("R10 no flag on drain-cycle write", ovf_flags, 0);
    rec_ready = 1'b1; tick(10);
    for (int i = 0; i < 5; i++) expect_rec(6, a + i, 0, 1);
    check_recs("R10 all five kept", 1'b1);
  endtask

  initial begin
    t_reset();
    t_short();
    t_span();
    t_sat();
    t_rr();
    t_ovf();
    t_same();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1-R11 run: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule